// File: doc/BRIEF.md
# Clock Rate Window Checker

This block checks that a monitored clock runs at the expected rate. It counts pulses of a measured-clock indication inside a reference window whose edges are given by a slow, always-running timer tick. When a window closes, the block compares the count with a programmed lower and upper bound. A count below the lower bound is reported as slow. A count above the upper bound, or a count that overflowed the counter, is reported as fast. A run of windows with no measured activity at all is reported as a timeout.

Both clocks are modelled as single-cycle enable pulses in one clock domain. Each bad verdict raises a one-cycle recoverable alert pulse and sets a sticky status flag. The flag stays set until software clears it through a clear input. Software turns measurement on with an enable. While the enable is low, all window state is discarded, but the sticky flags are kept.

Top module: `clk_rate_monitor`

## Requirements
- R1: After the enable rises, the first reference tick opens a window. Each later reference tick closes the current window and opens the next one. A measured tick in the same cycle as the closing reference tick counts toward the window being closed.
- R2: A closed window whose count is non-zero and below `minCount` sets `slowFlag` in the cycle after the closing reference tick.
- R3: A closed window whose count is above `maxCount` sets `fastFlag` in the cycle after the closing reference tick.
- R4: A count equal to `minCount` or equal to `maxCount` is in range. It sets no flag and raises no alert.
- R5: `alertPulse` is high for exactly one cycle, the cycle after the closing reference tick, for each window judged slow, fast or timed out. Bad windows closing in consecutive cycles give consecutive pulses.
- R6: A window with zero measured ticks is idle and is not judged slow or fast. When `timeoutWindows` consecutive idle windows have closed, `timeoutFlag` is set, the alert pulses, and the idle run count restarts from zero. A non-idle window also restarts the idle run count. A `timeoutWindows` value of 0 disables timeout.
- R7: The window counter saturates at 2^CNT_W-1. A window in which a tick arrives at saturation is judged fast whatever `maxCount` is. The overflow state is cleared when the next window opens.
- R8: The flags are sticky. `flagClr` bit 0 clears `slowFlag`, bit 1 clears `fastFlag` and bit 2 clears `timeoutFlag`. A flag that is set and cleared in the same cycle ends up set.
- R9: While `measEn` is low, ticks have no effect. Counting stops, the open window and the idle run count are discarded, and the flags keep their values. After re-enable, ticks before the first reference tick are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| measEn | input | 1 | Measurement enable |
| minCount | input | CNT_W | Lowest in-range window count |
| maxCount | input | CNT_W | Highest in-range window count |
| timeoutWindows | input | TO_W | Idle windows before timeout, 0 disables timeout |
| measTick | input | 1 | One pulse per measured-clock cycle |
| refTick | input | 1 | Reference window boundary pulse |
| flagClr | input | 3 | Flag clear strobes: bit 0 slow, bit 1 fast, bit 2 timeout |
| slowFlag | output | 1 | Sticky slow verdict |
| fastFlag | output | 1 | Sticky fast or overflow verdict |
| timeoutFlag | output | 1 | Sticky timeout verdict |
| alertPulse | output | 1 | One-cycle recoverable alert |

## Verification
The window count is driven with values below, at, between and above the two bounds. This separates an off-by-one at either compare from a correct inclusive range. One window closes with a measured tick in the same cycle as the reference tick, which shows whether that tick goes to the old window or the new one. Runs of empty windows with the limit set to two and then to zero separate idle detection from slow detection. Windows longer than the counter range, each followed by a short window, show that saturation reports fast and that the overflow state does not carry into the next window. Enable toggling in the middle of a window and clear strobes that coincide with new verdicts check what state is discarded and what is kept.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;

  typedef enum logic {
    WAIT_REF  = 1'b0,
    IN_WINDOW = 1'b1
  } winState_e;

  // control -> datapath
  typedef struct packed {
    logic clearCnt;
    logic countEn;
  } dpStrobe_t;

  // datapath -> control, valid in the cycle a window closes
  typedef struct packed {
    logic zero;
    logic slow;
    logic fast;
  } winVerdict_t;

endpackage

// File: rtl/clk_rate_datapath.sv
module clk_rate_datapath
  import clk_rate_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strb,
  input  logic             measTick,
  input  logic [CNT_W-1:0] minCount,
  input  logic [CNT_W-1:0] maxCount,
  output winVerdict_t      verdict
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic             ovfl;
  logic             carry;
  logic [CNT_W-1:0] total;
  logic             winOvfl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovfl  <= 1'b0;
    end else if (strb.clearCnt) begin
      count <= '0;
      ovfl  <= 1'b0;
    end else if (strb.countEn && measTick) begin
      if (count == CNT_MAX) ovfl  <= 1'b1;
      else                  count <= count + 1'b1;
    end
  end

  // closing total includes a tick coincident with the closing reference tick
  always_comb begin
    carry   = measTick && (count == CNT_MAX);
    total   = carry ? CNT_MAX : count + {{(CNT_W-1){1'b0}}, measTick};
    winOvfl = ovfl || carry;
    verdict.zero = !winOvfl && (total == '0);
    verdict.fast = winOvfl || (total > maxCount);
    verdict.slow = !winOvfl && (total < minCount);
  end

  assert_count_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearCnt |=> count >= $past(count));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovfl |-> count == CNT_MAX);

  assert_window_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearCnt |=> (count == '0) && !ovfl);

endmodule

// File: rtl/clk_rate_ctrl.sv
module clk_rate_ctrl
  import clk_rate_pkg::*;
#(
  parameter int TO_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            measEn,
  input  logic            refTick,
  input  logic [TO_W-1:0] timeoutWindows,
  input  logic [2:0]      flagClr,
  input  winVerdict_t     verdict,
  output dpStrobe_t       strb,
  output logic            slowFlag,
  output logic            fastFlag,
  output logic            timeoutFlag,
  output logic            alertPulse
);

  localparam int IW = TO_W + 1;

  winState_e       state;
  logic [TO_W-1:0] idleCnt;
  logic [IW-1:0]   idleNext;
  logic            closeWin;
  logic            slowEv, fastEv, toEv;

  assign closeWin      = measEn && (state == IN_WINDOW) && refTick;
  assign strb.clearCnt = !measEn || (state == WAIT_REF) || refTick;
  assign strb.countEn  = measEn && (state == IN_WINDOW);
  assign idleNext      = {1'b0, idleCnt} + 1'b1;

  always_comb begin
    slowEv = 1'b0;
    fastEv = 1'b0;
    toEv   = 1'b0;
    if (closeWin) begin
      if (verdict.zero) begin
        toEv = (timeoutWindows != '0) && (idleNext >= {1'b0, timeoutWindows});
      end else begin
        slowEv = verdict.slow;
        fastEv = verdict.fast;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state <= WAIT_REF;
    else if (!measEn)     state <= WAIT_REF;
    else if (refTick)     state <= IN_WINDOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (!measEn || (timeoutWindows == '0)) begin
      idleCnt <= '0;
    end else if (closeWin) begin
      if (verdict.zero && !toEv) idleCnt <= idleNext[TO_W-1:0];
      else                       idleCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slowFlag    <= 1'b0;
      fastFlag    <= 1'b0;
      timeoutFlag <= 1'b0;
      alertPulse  <= 1'b0;
    end else begin
      slowFlag    <= (slowFlag    && !flagClr[0]) || slowEv;
      fastFlag    <= (fastFlag    && !flagClr[1]) || fastEv;
      timeoutFlag <= (timeoutFlag && !flagClr[2]) || toEv;
      alertPulse  <= slowEv || fastEv || toEv;
    end
  end

  assert_alert_after_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alertPulse |-> $past(closeWin));

  assert_timeout_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeoutFlag) |-> $past(closeWin && verdict.zero));

  assert_slow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slowFlag && !flagClr[0]) |=> slowFlag);

  assert_slow_judged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slowFlag) |-> $past(closeWin && verdict.slow && !verdict.zero));

  assert_disable_drops_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !measEn |=> state == WAIT_REF);

endmodule

// File: rtl/clk_rate_monitor.sv
module clk_rate_monitor
  import clk_rate_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TO_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             measEn,
  input  logic [CNT_W-1:0] minCount,
  input  logic [CNT_W-1:0] maxCount,
  input  logic [TO_W-1:0]  timeoutWindows,
  input  logic             measTick,
  input  logic             refTick,
  input  logic [2:0]       flagClr,
  output logic             slowFlag,
  output logic             fastFlag,
  output logic             timeoutFlag,
  output logic             alertPulse
);

  dpStrobe_t   strb;
  winVerdict_t verdict;

  clk_rate_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .measTick (measTick),
    .minCount (minCount),
    .maxCount (maxCount),
    .verdict  (verdict)
  );

  clk_rate_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .measEn         (measEn),
    .refTick        (refTick),
    .timeoutWindows (timeoutWindows),
    .flagClr        (flagClr),
    .verdict        (verdict),
    .strb           (strb),
    .slowFlag       (slowFlag),
    .fastFlag       (fastFlag),
    .timeoutFlag    (timeoutFlag),
    .alertPulse     (alertPulse)
  );

endmodule

// File: tb/clk_rate_monitor_test.sv
module clk_rate_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 6;
  localparam int TW   = 3;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          measEn = 1'b0;
  logic [CW-1:0] minCount = 6'd5;
  logic [CW-1:0] maxCount = 6'd8;
  logic [TW-1:0] timeoutWindows = 3'd2;
  logic          measTick = 1'b0;
  logic          refTick = 1'b0;
  logic [2:0]    flagClr = 3'b000;
  logic          slowFlag, fastFlag, timeoutFlag, alertPulse;

  int checks = 0;
  int failures = 0;
  string currentReq = "R9";

  // reference model state
  bit mRun = 0;
  int mCnt = 0;
  int mIdle = 0;
  bit mSlow = 0, mFast = 0, mTo = 0, mAlert = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_rate_monitor #(.CNT_W(CW), .TO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .measEn(measEn), .minCount(minCount),
    .maxCount(maxCount), .timeoutWindows(timeoutWindows), .measTick(measTick),
    .refTick(refTick), .flagClr(flagClr), .slowFlag(slowFlag),
    .fastFlag(fastFlag), .timeoutFlag(timeoutFlag), .alertPulse(alertPulse)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit sEv = 0, fEv = 0, tEv = 0;
    if (!measEn) begin
      mRun = 0; mCnt = 0; mIdle = 0;
    end else if (!mRun) begin
      if (refTick) begin mRun = 1; mCnt = 0; end
    end else if (refTick) begin
      int total = mCnt + int'(measTick);
      if (total == 0) begin
        if (timeoutWindows == 0) mIdle = 0;
        else begin
          mIdle++;
          if (mIdle >= int'(timeoutWindows)) begin tEv = 1; mIdle = 0; end
        end
      end else begin
        mIdle = 0;
        if (total > MAXV || total > int'(maxCount)) fEv = 1;
        else if (total < int'(minCount)) sEv = 1;
      end
      mCnt = 0;
    end else begin
      mCnt += int'(measTick);
    end
    if (timeoutWindows == 0) mIdle = 0;
    mSlow  = (mSlow && !flagClr[0]) || sEv;
    mFast  = (mFast && !flagClr[1]) || fEv;
    mTo    = (mTo   && !flagClr[2]) || tEv;
    mAlert = sEv || fEv || tEv;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit r, bit m, logic [2:0] c);
    refTick = r; measTick = m; flagClr = c;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(currentReq, "slowFlag",    int'(slowFlag),    int'(mSlow));
    check(currentReq, "fastFlag",    int'(fastFlag),    int'(mFast));
    check(currentReq, "timeoutFlag", int'(timeoutFlag), int'(mTo));
    check(currentReq, "alertPulse",  int'(alertPulse),  int'(mAlert));
  endtask

  task automatic window(int n);
    for (int i = 0; i < n; i++) step(0, 1, 3'b000);
    step(1, 0, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "reset slowFlag", int'(slowFlag), 0);
    check("R8", "reset alertPulse", int'(alertPulse), 0);
    rst_n = 1'b1;

    // R9: ticks while disabled and before the first reference tick
    currentReq = "R9";
    for (int i = 0; i < 3; i++) step(1, 1, 3'b000);
    measEn = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 1, 3'b000);
    step(1, 0, 3'b000);

    // R4: count equal to the lower bound
    currentReq = "R4";
    window(5);
    check("R4", "min edge alert", int'(alertPulse), 0);

    // R1: eight ticks, last one coincident with closing reference tick
    currentReq = "R1";
    for (int i = 0; i < 7; i++) step(0, 1, 3'b000);
    step(1, 1, 3'b000);
    check("R1", "coincident tick counted", int'(fastFlag | slowFlag), 0);

    // R2 and R5: slow window, then alert drops
    currentReq = "R2";
    window(3);
    check("R2", "slowFlag", int'(slowFlag), 1);
    check("R5", "alert on slow", int'(alertPulse), 1);
    currentReq = "R5";
    step(0, 0, 3'b000);
    check("R5", "alert single cycle", int'(alertPulse), 0);

    // R8: clear, and set colliding with clear
    currentReq = "R8";
    step(0, 0, 3'b001);
    check("R8", "slow cleared", int'(slowFlag), 0);
    step(0, 1, 3'b000);
    step(0, 1, 3'b000);
    step(1, 0, 3'b001);
    check("R8", "set wins over clear", int'(slowFlag), 1);
    step(0, 0, 3'b001);

    // R3: above the upper bound, and nine versus eight
    currentReq = "R3";
    window(9);
    check("R3", "fastFlag", int'(fastFlag), 1);
    step(0, 0, 3'b010);

    // R5: bad windows closing back to back
    currentReq = "R5";
    step(1, 1, 3'b000);
    step(1, 1, 3'b000);
    check("R5", "consecutive alert", int'(alertPulse), 1);
    step(0, 0, 3'b011);

    // R7: saturation with the upper bound at full scale
    currentReq = "R7";
    maxCount = 6'(MAXV);
    window(MAXV);
    check("R7", "full scale in range", int'(fastFlag), 0);
    window(70);
    check("R7", "overflow is fast", int'(fastFlag), 1);
    step(0, 0, 3'b010);
    window(6);
    check("R7", "overflow cleared", int'(fastFlag), 0);
    maxCount = 6'd8;
    window(8);
    check("R4", "max edge in range", int'(fastFlag), 0);

    // R6: idle windows
    currentReq = "R6";
    window(0);
    check("R6", "one idle no timeout", int'(timeoutFlag), 0);
    window(0);
    check("R6", "timeoutFlag", int'(timeoutFlag), 1);
    check("R6", "slow not set by idle", int'(slowFlag), 0);
    step(0, 0, 3'b100);
    window(0);
    window(6);
    window(0);
    check("R6", "run restarted", int'(timeoutFlag), 0);
    timeoutWindows = 3'd0;
    for (int i = 0; i < 4; i++) window(0);
    check("R6", "disabled timeout", int'(timeoutFlag), 0);
    timeoutWindows = 3'd2;

    // R9: disable mid window discards the partial count
    currentReq = "R9";
    for (int i = 0; i < 3; i++) step(0, 1, 3'b000);
    measEn = 1'b0;
    step(0, 1, 3'b000);
    step(1, 1, 3'b000);
    measEn = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 1, 3'b000);
    step(1, 0, 3'b000);
    window(5);
    check("R9", "partial window dropped", int'(fastFlag | slowFlag), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule